// File: doc/BRIEF.md
# CPU Bus Cycle Decoder with Display Control Register

This block turns each CPU data-strobe cycle into chip enables for the rest of the system. The two top address bits split the 256 KB space into four 64 KB regions: ROM, IO, and two RAM banks. For ROM it drives an active-high ROM enable and an immediate transfer acknowledge. For the IO region it drives an active-low enable for a companion peripheral chip. The same IO decode also steers writes into a three-bit display control register.

The CPU's lower address bits are not wired to this block on dedicated pins. While A17 is low, the external multiplexers present the DRAM column address on the shared 8-bit address bus. That bus carries A15, A14, A13, A12, A6, A5, A1 and A0, and the block decodes the IO space from it.

The register cannot be read back. Its three stored bits sit at scattered data-bus positions. How many upper address bits take part in the register decode is set by a parameter, which fixes the alias footprint at 16 KB, 32 KB or 64 KB.

Top module: `bus_decode_ctl`

## Requirements
- R1: `rom_en` is 1 exactly when `strobe_n`=0, `wr_n`=1 and {`a17`,`a16`}=00. Region codes are 00 ROM, 01 IO, 10 RAM bank 0 and 11 RAM bank 1.
- R2: A write cycle (`wr_n`=0) into the ROM region leaves `rom_en` at 0.
- R3: `dtack_n` is 0 exactly when `strobe_n`=0 and the region is ROM, for both reads and writes. In every other case it is 1.
- R4: The shared address bus `col_addr` carries bit 0=A0, 1=A1, 2=A5, 3=A6, 4=A12, 5=A13, 6=A14 and 7=A15. `periph_en_n` is 0 when `strobe_n`=0, the region is IO, A6=0 and `vid_addr_en`=0.
- R5: While `vid_addr_en`=1, `periph_en_n` stays 1 for any other input pattern.
- R6: A register write happens when `strobe_n`=0, `wr_n`=0, the region is IO, A6=1 and A1=A0=1 (address 0x18063 qualifies). It loads data bit 7 into `screen_sel`, bit 3 into `hires_mode` and bit 1 into `blank`. The new value is visible on the outputs after that clock edge.
- R7: Data bits other than 7, 3 and 1 have no effect on the register outputs.
- R8: With the default 16 KB aliasing, a register write also needs A15=1 and A14=0; otherwise the register is unchanged. The 32 KB setting checks only A15=1, and the 64 KB setting checks neither.
- R9: With A5 checking enabled (the default), a write with A5=0 leaves the register unchanged. A write with A1=0 or A0=0 also leaves it unchanged.
- R10: A read cycle at the register's address leaves the register unchanged.
- R11: A synchronous active-high `rst` clears all three register bits to 0.
- R12: Cycles in either RAM region (`a17`=1) drive no enable and no acknowledge, and never write the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_n | input | 1 | CPU data strobe, active low |
| wr_n | input | 1 | Transfer direction: 0 write, 1 read |
| a17 | input | 1 | CPU address bit 17 |
| a16 | input | 1 | CPU address bit 16 |
| col_addr | input | 8 | Shared DRAM address bus carrying the column part of the CPU address |
| vid_addr_en | input | 1 | High while the video fetcher owns the address bus |
| data_in | input | 8 | CPU data bus |
| rom_en | output | 1 | ROM output enable, active high |
| periph_en_n | output | 1 | Peripheral chip enable, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| screen_sel | output | 1 | Display buffer select |
| hires_mode | output | 1 | Display mode select |
| blank | output | 1 | Display blank |

## Verification
The bench probes near-miss addresses around the register. It tries A14 set, A15 clear, A5 clear and A1 clear, and a design that under-decodes any of these would take the write and change an output. Data patterns are chosen so the register bits sit next to the bits it must ignore. A wrong bit lane would therefore show a stored 1 where a 0 belongs, or the reverse. Peripheral enables are checked with the video fetcher both active and idle, and RAM-region writes that carry a matching column pattern are also driven. A missing video gate would drive the peripheral enable low, and a missing region check would corrupt the register.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;

    typedef enum logic [1:0] {
        RGN_ROM  = 2'b00,
        RGN_IO   = 2'b01,
        RGN_RAM0 = 2'b10,
        RGN_RAM1 = 2'b11
    } region_e;

    typedef enum logic [1:0] {
        ALIAS_16K = 2'd0,
        ALIAS_32K = 2'd1,
        ALIAS_64K = 2'd2
    } alias_e;

    // Column-phase layout of the shared DRAM address bus, MSB first.
    typedef struct packed {
        logic a15;
        logic a14;
        logic a13;
        logic a12;
        logic a6;
        logic a5;
        logic a1;
        logic a0;
    } col_addr_t;

    typedef struct packed {
        logic screen_sel;
        logic hires;
        logic blank;
    } disp_ctrl_t;

    localparam int COL_W      = $bits(col_addr_t);
    localparam int BIT_SCREEN = 7;
    localparam int BIT_MODE   = 3;
    localparam int BIT_BLANK  = 1;

    function automatic region_e region_of(input logic hi, input logic lo);
        return region_e'({hi, lo});
    endfunction

    function automatic logic upper_ok(input alias_e mode, input col_addr_t c);
        case (mode)
            ALIAS_16K: return c.a15 & ~c.a14;
            ALIAS_32K: return c.a15;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/bus_region_dec.sv
module bus_region_dec
    import bus_dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe_n,
    input  logic      wr_n,
    input  logic      a17,
    input  logic      a16,
    input  col_addr_t col,
    input  logic      vid_en,
    output logic      rom_en,
    output logic      periph_en_n,
    output logic      dtack_n,
    output logic      io_write
);
    region_e rgn;
    logic    active;

    always_comb begin
        rgn         = region_of(a17, a16);
        active      = ~strobe_n;
        rom_en      = active & wr_n & (rgn == RGN_ROM);
        dtack_n     = ~(active & (rgn == RGN_ROM));
        periph_en_n = ~(active & (rgn == RGN_IO) & ~col.a6 & ~vid_en);
        io_write    = active & ~wr_n & (rgn == RGN_IO);
    end

    // R3
    rom_ack_chk: assert property (@(posedge clk) disable iff (rst)
        rom_en |-> !dtack_n);

    // R1
    enable_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rom_en && !periph_en_n));

    // R5
    vid_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !periph_en_n |-> !vid_en);

    // R12
    ram_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        a17 |-> (periph_en_n && !rom_en && dtack_n && !io_write));

endmodule

// File: rtl/io_reg_match.sv
module io_reg_match
    import bus_dec_pkg::*;
#(
    parameter alias_e ALIAS    = ALIAS_16K,
    parameter bit     CHECK_A5 = 1'b1
) (
    input  logic      io_write,
    input  col_addr_t col,
    output logic      hit
);
    logic a5_ok;

    generate
        if (CHECK_A5) begin : g_a5
            assign a5_ok = col.a5;
        end else begin : g_no_a5
            assign a5_ok = 1'b1;
        end
    endgenerate

    assign hit = io_write & col.a6 & col.a1 & col.a0 & a5_ok & upper_ok(ALIAS, col);

endmodule

// File: rtl/disp_ctrl_reg.sv
module disp_ctrl_reg
    import bus_dec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [DATA_W-1:0] data,
    output disp_ctrl_t        ctrl
);
    disp_ctrl_t nxt;

    always_comb begin
        nxt.screen_sel = data[BIT_SCREEN];
        nxt.hires      = data[BIT_MODE];
        nxt.blank      = data[BIT_BLANK];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (hit) begin
            ctrl <= nxt;
        end
    end

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(ctrl));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ctrl == '0));

    // R6
    load_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> (ctrl.screen_sel == $past(data[BIT_SCREEN]) &&
                 ctrl.hires == $past(data[BIT_MODE]) &&
                 ctrl.blank == $past(data[BIT_BLANK])));

endmodule

// File: rtl/bus_decode_ctl.sv
module bus_decode_ctl
    import bus_dec_pkg::*;
#(
    parameter int     DATA_W   = 8,
    parameter alias_e ALIAS    = ALIAS_16K,
    parameter bit     CHECK_A5 = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_n,
    input  logic              wr_n,
    input  logic              a17,
    input  logic              a16,
    input  logic [COL_W-1:0]  col_addr,
    input  logic              vid_addr_en,
    input  logic [DATA_W-1:0] data_in,
    output logic              rom_en,
    output logic              periph_en_n,
    output logic              dtack_n,
    output logic              screen_sel,
    output logic              hires_mode,
    output logic              blank
);
    localparam int TOP_BIT = BIT_SCREEN;

    initial begin
        if (DATA_W <= TOP_BIT) $error("DATA_W too narrow for register bits");
    end

    col_addr_t  col;
    logic       io_write;
    logic       reg_hit;
    disp_ctrl_t ctrl;

    assign col = col_addr_t'(col_addr);

    bus_region_dec u_region (
        .clk        (clk),
        .rst        (rst),
        .strobe_n   (strobe_n),
        .wr_n       (wr_n),
        .a17        (a17),
        .a16        (a16),
        .col        (col),
        .vid_en     (vid_addr_en),
        .rom_en     (rom_en),
        .periph_en_n(periph_en_n),
        .dtack_n    (dtack_n),
        .io_write   (io_write)
    );

    io_reg_match #(
        .ALIAS   (ALIAS),
        .CHECK_A5(CHECK_A5)
    ) u_match (
        .io_write(io_write),
        .col     (col),
        .hit     (reg_hit)
    );

    disp_ctrl_reg #(
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk (clk),
        .rst (rst),
        .hit (reg_hit),
        .data(data_in),
        .ctrl(ctrl)
    );

    assign screen_sel = ctrl.screen_sel;
    assign hires_mode = ctrl.hires;
    assign blank      = ctrl.blank;

endmodule

// File: tb/bus_decode_ctl_tb.sv
module bus_decode_ctl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       a17 = 1'b0;
    logic       a16 = 1'b0;
    logic [7:0] col_addr = 8'h00;
    logic       vid_addr_en = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       rom_en, periph_en_n, dtack_n, screen_sel, hires_mode, blank;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    string      q_tag[$];
    logic [5:0] q_exp[$];
    logic [2:0] model = 3'b000;

    always #2.5 clk = ~clk;

    bus_decode_ctl u_dut (
        .clk        (clk),
        .rst        (rst),
        .strobe_n   (strobe_n),
        .wr_n       (wr_n),
        .a17        (a17),
        .a16        (a16),
        .col_addr   (col_addr),
        .vid_addr_en(vid_addr_en),
        .data_in    (data_in),
        .rom_en     (rom_en),
        .periph_en_n(periph_en_n),
        .dtack_n    (dtack_n),
        .screen_sel (screen_sel),
        .hires_mode (hires_mode),
        .blank      (blank)
    );

    // Column bus: bit7 A15, 6 A14, 5 A13, 4 A12, 3 A6, 2 A5, 1 A1, 0 A0.
    function automatic logic [7:0] col_of(input bit b15, input bit b14, input bit b6,
                                          input bit b5, input bit b1, input bit b0);
        return {b15, b14, 2'b00, b6, b5, b1, b0};
    endfunction

    task automatic drive(input string tag, input bit r, input bit sn, input bit wn,
                         input bit h17, input bit h16, input logic [7:0] c,
                         input bit v, input logic [7:0] d);
        bit e_rom, e_per, e_dtk, hit;
        @(posedge clk);
        #1;
        rst = r; strobe_n = sn; wr_n = wn; a17 = h17; a16 = h16;
        col_addr = c; vid_addr_en = v; data_in = d;
        e_rom = !sn && wn && !h17 && !h16;
        e_dtk = !(!sn && !h17 && !h16);
        e_per = !(!sn && !h17 && h16 && !c[3] && !v);
        q_tag.push_back(tag);
        q_exp.push_back({e_rom, e_per, e_dtk, model});
        hit = !sn && !wn && !h17 && h16 && c[3] && c[1] && c[0] && c[2] && c[7] && !c[6];
        if (r) model = 3'b000;
        else if (hit) model = {d[7], d[3], d[1]};
    endtask

    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            string tag;
            logic [5:0] exp, act;
            tag = q_tag.pop_front();
            exp = q_exp.pop_front();
            act = {rom_en, periph_en_n, dtack_n, screen_sel, hires_mode, blank};
            checks++;
            if (act !== exp) begin
                failures++;
                $display("FAIL %s actual=%b expected=%b", tag, act, exp);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam logic [7:0] REG_COL = 8'b1000_1111;

    initial begin
        repeat (2) @(posedge clk);
        drive("R11 reset", 1, 1, 1, 0, 0, 8'h00, 0, 8'h00);
        drive("R11 idle", 0, 1, 1, 0, 0, 8'h00, 0, 8'h00);
        drive("R1 rom read", 0, 0, 1, 0, 0, 8'h00, 0, 8'h00);
        drive("R1 rom strobe high", 0, 1, 1, 0, 0, 8'h00, 0, 8'h00);
        drive("R2 rom write", 0, 0, 0, 0, 0, 8'h00, 0, 8'h00);
        drive("R3 io no ack", 0, 0, 1, 0, 1, 8'h00, 0, 8'h00);
        drive("R4 periph A6=0", 0, 0, 1, 0, 1, col_of(1, 0, 0, 1, 1, 1), 0, 8'h00);
        drive("R5 periph vid", 0, 0, 1, 0, 1, col_of(1, 0, 0, 1, 1, 1), 1, 8'h00);
        drive("R4 periph A6=1", 0, 0, 1, 0, 1, REG_COL, 0, 8'h00);
        drive("R6 write 8A", 0, 0, 0, 0, 1, REG_COL, 0, 8'h8A);
        drive("R6 readout", 0, 1, 1, 0, 0, 8'h00, 0, 8'h00);
        drive("R7 write 75", 0, 0, 0, 0, 1, REG_COL, 0, 8'h75);
        drive("R7 readout", 0, 1, 1, 0, 0, 8'h00, 0, 8'h00);
        drive("R7 write 7F", 0, 0, 0, 0, 1, REG_COL, 0, 8'h7F);
        drive("R7 readout2", 0, 1, 1, 0, 0, 8'h00, 0, 8'h00);
        drive("R8 A14 set", 0, 0, 0, 0, 1, col_of(1, 1, 1, 1, 1, 1), 0, 8'h80);
        drive("R8 A15 clear", 0, 0, 0, 0, 1, col_of(0, 0, 1, 1, 1, 1), 0, 8'h80);
        drive("R9 A5 clear", 0, 0, 0, 0, 1, col_of(1, 0, 1, 0, 1, 1), 0, 8'h80);
        drive("R9 A1 clear", 0, 0, 0, 0, 1, col_of(1, 0, 1, 1, 0, 1), 0, 8'h80);
        drive("R10 read reg", 0, 0, 1, 0, 1, REG_COL, 0, 8'h80);
        drive("R12 ram0 write", 0, 0, 0, 1, 0, REG_COL, 0, 8'h80);
        drive("R12 ram1 write", 0, 0, 0, 1, 1, REG_COL, 0, 8'h80);
        drive("R12 readout", 0, 1, 1, 0, 0, 8'h00, 0, 8'h00);
        drive("R6 vid write", 0, 0, 0, 0, 1, REG_COL, 1, 8'h88);
        drive("R6 readout2", 0, 1, 1, 0, 0, 8'h00, 0, 8'h00);
        drive("R11 reset again", 1, 1, 1, 0, 0, 8'h00, 0, 8'h00);
        drive("R11 cleared", 0, 1, 1, 0, 0, 8'h00, 0, 8'h00);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule